// File: doc/BRIEF.md
# Multi-Width Serial SRAM Slave Interface

This block is the device-side front end of a small serial SRAM. A host drives an active-low chip select, a serial clock and an active-low pause input, and exchanges bits over four shared data pins. Each transaction begins with an 8-bit command. Read and write commands then take a 24-bit address and stream bytes to or from an on-chip byte array. The address advances after every byte and wraps at the top of the array. Other commands change the bus width, or write and read an 8-bit configuration byte.

The bus starts 1 bit wide. Commands can widen it to 2 or 4 bits, and it stays at that width across transactions until a return command or a reset. All pins are sampled into the system clock domain through a synchroniser. Serial clock edges are then found by comparing successive samples, so the serial clock must run well below the system clock (at least six system cycles per half period with the default two-stage synchroniser).

Top module: `sersram_slave`

## Requirements
- R1: After reset the bus is 1 bit wide, the configuration byte reads 0x00 and every bit of `sio_oe` is 0.
- R2: In 1-bit mode the input is `sio_in[0]` and the output is `sio_out[1]`. Bits are sampled on the rising serial clock edge, output changes after the falling edge, and every field is sent MSB first.
- R3: Command 0x02 followed by a 24-bit address stores each later complete byte at the address and then advances the address by one. Only the low ADDR_W address bits are used and the upper bits are ignored.
- R4: Command 0x03 followed by a 24-bit address returns the byte at the address, then the following bytes, and wraps from DEPTH-1 to 0.
- R5: Command 0x3B selects 2-bit mode (pins [1:0], pin 1 carries the more significant bit). Command 0x38 selects 4-bit mode (pins [3:0], pin 3 most significant). The new width takes effect for the next transaction and persists across transactions. Commands are always sent at the current width.
- R6: Command 0xFF, sent at the current width, returns the bus to 1-bit mode.
- R7: Command 0x01 writes one data byte into the configuration byte. Command 0x05 returns that byte, repeated for as long as the host clocks.
- R8: Raising chip select discards any partial byte, including an unfinished write byte, and the next transaction starts with a command.
- R9: In 1-bit and 2-bit modes, a low `hold_n` freezes the transfer: clock edges are ignored, `sio_oe` is 0, and the transfer resumes where it stopped once `hold_n` rises.
- R10: In 4-bit mode `hold_n` has no effect.
- R11: `sio_oe` is nonzero only in the output phase of a read or configuration read, and equals 4'b0010, 4'b0011 or 4'b1111 for the 1-, 2- or 4-bit mode.
- R12: After an unknown command, the rest of the transaction is ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| hold_n | input | 1 | Pause request, active low |
| sio_in | input | 4 | Data pins as seen by the block |
| sio_out | output | 4 | Data driven onto the pins |
| sio_oe | output | 4 | Per-pin output enable |

## Verification
A wrong bit count or a wrong bus-width state shows up as a shifted or corrupted read byte. This becomes visible at the next read, within one byte time of the error. A wrong address pointer shows up as data from the wrong location, which a full array of known contents exposes on the first byte read back. Enable faults appear at once on `sio_oe`, during write phases, during hold, or as a mask that does not match the mode.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [1:0] {
        BUS_X1 = 2'd0,
        BUS_X2 = 2'd1,
        BUS_X4 = 2'd2
    } bus_e;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADR,
        PH_WDAT,
        PH_RDAT,
        PH_CFGW,
        PH_CFGR,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic       cs_n;
        logic       hold_n;
        logic       sck;
        logic [3:0] sio;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0, sio: 4'h0};

    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_X4    = 8'h38;
    localparam logic [7:0] CMD_X2    = 8'h3B;
    localparam logic [7:0] CMD_X1    = 8'hFF;
    localparam logic [7:0] CMD_CFGR  = 8'h05;
    localparam logic [7:0] CMD_CFGW  = 8'h01;

    function automatic logic [3:0] lanes(bus_e b);
        case (b)
            BUS_X2:  return 4'd2;
            BUS_X4:  return 4'd4;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(bus_e b);
        case (b)
            BUS_X2:  return 4'b0011;
            BUS_X4:  return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/srm_sync.sv
module srm_sync #(
    parameter int             W       = 7,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srm_mem.sv
module srm_mem #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
    end

    assign rdata = arr[raddr];
endmodule

// File: rtl/sersram_slave.sv
module sersram_slave
    import srm_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       hold_n,
    input  logic [3:0] sio_in,
    output logic [3:0] sio_out,
    output logic [3:0] sio_oe
);
    localparam int PW = $bits(pins_t);

    pins_t          raw_pins, pins;
    logic [PW-1:0]  pins_vec;

    assign raw_pins = '{cs_n: cs_n, hold_n: hold_n, sck: sck, sio: sio_in};

    srm_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (pins_vec)
    );
    assign pins = pins_t'(pins_vec);

    bus_e              bus;
    phase_e            phase;
    logic [2:0]        bitcnt;
    logic [6:0]        shreg;
    logic [1:0]        abyte;
    logic              rd_op;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        cfg;
    logic              drv;
    logic [3:0]        dout;
    logic              sck_q;

    logic       paused, rise, fall, byte_done, is_rd, mem_we;
    logic [3:0] step, next_cnt, chunk;
    logic [7:0] nxt, rbyte, mem_rdata;

    assign paused    = !pins.hold_n && (bus != BUS_X4);
    assign rise      = pins.sck && !sck_q && !paused;
    assign fall      = !pins.sck && sck_q && !paused;
    assign step      = lanes(bus);
    assign next_cnt  = {1'b0, bitcnt} + step;
    assign byte_done = next_cnt[3];
    assign is_rd     = (phase == PH_RDAT) || (phase == PH_CFGR);
    assign mem_we    = rise && !pins.cs_n && (phase == PH_WDAT) && byte_done;
    assign rbyte     = (phase == PH_CFGR) ? cfg : mem_rdata;

    always_comb begin
        unique case (bus)
            BUS_X1:  nxt = {shreg[6:0], pins.sio[0]};
            BUS_X2:  nxt = {shreg[5:0], pins.sio[1:0]};
            default: nxt = {shreg[3:0], pins.sio};
        endcase
    end

    always_comb begin
        unique case (bus)
            BUS_X1:  chunk = {2'b00, rbyte[3'd7 - bitcnt], 1'b0};
            BUS_X2:  chunk = {2'b00, rbyte[3'd7 - bitcnt], rbyte[3'd6 - bitcnt]};
            default: chunk = bitcnt[2] ? rbyte[3:0] : rbyte[7:4];
        endcase
    end

    srm_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr),
        .wdata (nxt),
        .raddr (addr),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus    <= BUS_X1;
            phase  <= PH_CMD;
            bitcnt <= '0;
            shreg  <= '0;
            abyte  <= '0;
            rd_op  <= 1'b0;
            addr   <= '0;
            cfg    <= '0;
            drv    <= 1'b0;
            dout   <= '0;
            sck_q  <= 1'b0;
        end else begin
            sck_q <= pins.sck;
            if (pins.cs_n) begin
                phase  <= PH_CMD;
                bitcnt <= '0;
                abyte  <= '0;
                drv    <= 1'b0;
            end else if (rise && !is_rd) begin
                shreg  <= nxt[6:0];
                bitcnt <= next_cnt[2:0];
                if (byte_done) begin
                    unique case (phase)
                        PH_CMD: begin
                            unique case (nxt)
                                CMD_READ:  begin phase <= PH_ADR; rd_op <= 1'b1; end
                                CMD_WRITE: begin phase <= PH_ADR; rd_op <= 1'b0; end
                                CMD_X4:    begin bus <= BUS_X4; phase <= PH_DROP; end
                                CMD_X2:    begin bus <= BUS_X2; phase <= PH_DROP; end
                                CMD_X1:    begin bus <= BUS_X1; phase <= PH_DROP; end
                                CMD_CFGR:  phase <= PH_CFGR;
                                CMD_CFGW:  phase <= PH_CFGW;
                                default:   phase <= PH_DROP;
                            endcase
                        end
                        PH_ADR: begin
                            addr  <= ADDR_W'({addr, nxt});
                            abyte <= abyte + 2'd1;
                            if (abyte == 2'd2) phase <= rd_op ? PH_RDAT : PH_WDAT;
                        end
                        PH_WDAT: addr <= addr + 1'b1;
                        PH_CFGW: begin cfg <= nxt; phase <= PH_DROP; end
                        default: ;
                    endcase
                end
            end else if (fall && is_rd) begin
                drv    <= 1'b1;
                dout   <= chunk;
                bitcnt <= next_cnt[2:0];
                if (byte_done && phase == PH_RDAT) addr <= addr + 1'b1;
            end
        end
    end

    assign sio_out = dout;
    assign sio_oe  = (drv && is_rd && !pins.cs_n && !paused) ? lane_mask(bus) : 4'h0;

    // Width changes only at a completed command byte (R5, R6)
    assert_width_switch_R5: assert property (@(posedge clk) disable iff (rst)
        (bus != $past(bus)) |-> ($past(phase) == PH_CMD && $past(rise)));

    // A paused transfer keeps all its progress (R9)
    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (paused && !pins.cs_n) |=> ($stable(phase) && $stable(bitcnt) && $stable(addr) && $stable(dout)));

    // Chip select high restarts the command phase (R8)
    assert_cs_restart_R8: assert property (@(posedge clk) disable iff (rst)
        pins.cs_n |=> (phase == PH_CMD && bitcnt == 3'd0));

    // Every stored byte moves the pointer forward by one (R3)
    assert_write_advance_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (addr == ADDR_W'($past(addr) + 1'b1)));

    // Bit counter stays aligned to the lane count (R2)
    assert_lane_align_R2: assert property (@(posedge clk) disable iff (rst)
        ((bitcnt & 3'(step - 4'd1)) == 3'd0));

    // Enables appear only in an output phase (R11)
    assert_oe_phase_R11: assert property (@(posedge clk) disable iff (rst)
        (sio_oe != 4'h0) |-> (is_rd && drv));
endmodule

// File: tb/sersram_slave_bench.sv
module sersram_slave_bench;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int H      = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
    logic [3:0] sio_in = 4'h0;
    logic [3:0] sio_out, sio_oe;

    always #4 clk = ~clk;

    sersram_slave #(.ADDR_W(ADDR_W)) u_sersram_slave (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
    );

    int checks = 0;
    int errors = 0;
    int cur_w  = 1;
    logic [7:0] ref_mem [DEPTH];
    logic [7:0] ref_cfg = 8'h00;

    function automatic logic [3:0] exp_mask(int w);
        return (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0010;
    endfunction

    function automatic logic [7:0] ref_rd(int a);
        return ref_mem[a % DEPTH];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_part(input logic [7:0] b, input int lo, input int hi);
        for (int i = lo; i < hi; i += cur_w) begin
            logic [7:0] t;
            t = b << i;
            sio_in = (cur_w == 4) ? t[7:4] : (cur_w == 2) ? {2'b00, t[7:6]} : {3'b000, t[7]};
            wclk(H); sck = 1'b1; wclk(H); sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_part(b, 0, 8);
    endtask

    task automatic recv_byte(output logic [7:0] v, output bit oe_ok);
        v = 8'h00; oe_ok = 1'b1;
        for (int i = 0; i < 8; i += cur_w) begin
            wclk(H);
            if (sio_oe != exp_mask(cur_w)) oe_ok = 1'b0;
            if (cur_w == 4)      v = {v[3:0], sio_out};
            else if (cur_w == 2) v = {v[5:0], sio_out[1:0]};
            else                 v = {v[6:0], sio_out[1]};
            sck = 1'b1; wclk(H); sck = 1'b0;
        end
    endtask

    task automatic begin_tx; cs_n = 1'b0; sio_in = 4'h0; wclk(H); endtask
    task automatic end_tx;   wclk(H); cs_n = 1'b1; wclk(2*H); endtask

    task automatic send_addr(input logic [23:0] a);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    endtask

    task automatic wr_tx(input logic [23:0] a, input int n);
        begin_tx; send_byte(8'h02); send_addr(a);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            send_byte(d);
            ref_mem[(int'(a) + k) % DEPTH] = d;
        end
        end_tx;
    endtask

    task automatic rd_tx(input logic [23:0] a, input int n, input string tag);
        begin_tx; send_byte(8'h03); send_addr(a);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v; bit ok;
            recv_byte(v, ok);
            check(v == ref_rd(int'(a) + k) && ok, tag, {23'd0, ok, v}, {24'd1, ref_rd(int'(a) + k)});
        end
        end_tx;
    endtask

    task automatic mode_tx(input logic [7:0] op, input int new_w);
        begin_tx; send_byte(op); end_tx;
        cur_w = new_w;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        bit ok;
        void'($urandom(32'd20240611));
        wclk(5); rst = 1'b0; wclk(4);

        // R1: reset state
        check(sio_oe == 4'h0, "R1 oe after reset", {28'd0, sio_oe}, 0);
        begin_tx; send_byte(8'h05); recv_byte(v, ok); end_tx;
        check(v == 8'h00 && ok, "R1 cfg reset / R2 spi out pin", {23'd0, ok, v}, {24'd1, 8'h00});

        // R5: fill array in 4-bit mode, one long stream
        mode_tx(8'h38, 4);
        begin_tx; send_byte(8'h02); send_addr(24'h0);
        for (int k = 0; k < DEPTH; k++) begin
            ref_mem[k] = 8'((k * 7 + 3) ^ (k >> 3));
            send_byte(ref_mem[k]);
        end
        end_tx;
        rd_tx(24'h0, 3, "R5 x4 read after fill");
        // R6: return to 1-bit mode
        mode_tx(8'hFF, 1);
        rd_tx(24'd100, 2, "R6 x1 after return");

        // R2/R3: 1-bit write and read
        wr_tx(24'h000010, 4);
        rd_tx(24'h000010, 4, "R2 R3 x1 write/read");
        // R4: wrap at top
        wr_tx(24'(DEPTH - 2), 4);
        rd_tx(24'(DEPTH - 2), 4, "R4 wrap");
        // R3: upper address bits ignored
        wr_tx(24'hAB0000 | 24'd77, 1);
        rd_tx(24'd77, 1, "R3 upper addr ignored");

        // R7: configuration byte
        begin_tx; send_byte(8'h01); send_byte(8'hA5); end_tx; ref_cfg = 8'hA5;
        begin_tx; send_byte(8'h05);
        recv_byte(v, ok); check(v == ref_cfg && ok, "R7 cfg read", {23'd0, ok, v}, {24'd1, ref_cfg});
        recv_byte(v, ok); check(v == ref_cfg, "R7 cfg repeat", v, ref_cfg);
        end_tx;

        // R8: abort mid byte and mid command
        ref_mem[200] = 8'h3C; ref_mem[201] = 8'hC3;
        begin_tx; send_byte(8'h02); send_addr(24'd200); send_byte(8'h3C); send_byte(8'hC3); end_tx;
        begin_tx; send_byte(8'h02); send_addr(24'd200); send_byte(8'h11); send_part(8'h22, 0, 4); end_tx;
        ref_mem[200] = 8'h11;
        begin_tx; send_part(8'h03, 0, 5); end_tx;
        rd_tx(24'd200, 2, "R8 partial write dropped");

        // R12: unknown command swallows the rest
        begin_tx; send_byte(8'h77); send_byte(8'h02); send_addr(24'd300);
        check(sio_oe == 4'h0, "R12 no drive after unknown", {28'd0, sio_oe}, 0);
        send_byte(8'h99); end_tx;
        rd_tx(24'd300, 1, "R12 unknown ignored");

        // R11: no drive during a write data phase
        begin_tx; send_byte(8'h02); send_addr(24'd400); send_part(8'h5A, 0, 4);
        check(sio_oe == 4'h0, "R11 no drive in write", {28'd0, sio_oe}, 0);
        send_part(8'h5A, 4, 8); end_tx; ref_mem[400] = 8'h5A;

        // R9: hold in 1-bit mode mid write byte
        begin_tx; send_byte(8'h02); send_addr(24'd500); send_part(8'hB6, 0, 4);
        hold_n = 1'b0; wclk(H);
        for (int k = 0; k < 3; k++) begin sio_in = 4'($urandom); wclk(H); sck = 1'b1; wclk(H); sck = 1'b0; end
        wclk(H); hold_n = 1'b1; wclk(H);
        send_part(8'hB6, 4, 8); end_tx; ref_mem[500] = 8'hB6;
        rd_tx(24'd500, 1, "R9 x1 hold resume write");

        // R9: hold during 1-bit read, pins released
        begin_tx; send_byte(8'h03); send_addr(24'd500); wclk(H);
        hold_n = 1'b0; wclk(6);
        check(sio_oe == 4'h0, "R9 oe off during hold", {28'd0, sio_oe}, 0);
        sck = 1'b1; wclk(H); sck = 1'b0; wclk(H);
        hold_n = 1'b1; wclk(4);
        recv_byte(v, ok); check(v == ref_mem[500] && ok, "R9 x1 read after hold", {23'd0, ok, v}, {24'd1, ref_mem[500]});
        end_tx;

        // R5/R9: 2-bit mode with hold inside the address
        mode_tx(8'h3B, 2);
        begin_tx; send_byte(8'h03); send_byte(8'h00); send_part(8'h02, 0, 4);
        hold_n = 1'b0; wclk(H);
        for (int k = 0; k < 2; k++) begin sio_in = 4'hF; wclk(H); sck = 1'b1; wclk(H); sck = 1'b0; end
        hold_n = 1'b1; wclk(H);
        send_part(8'h02, 4, 8); send_byte(8'h58);
        recv_byte(v, ok); check(v == ref_mem[600] && ok, "R9 R11 x2 hold in address", {23'd0, ok, v}, {24'd1, ref_mem[600]});
        end_tx;
        wr_tx(24'd650, 3);
        rd_tx(24'd650, 3, "R5 x2 write/read");

        // R10: hold ignored in 4-bit mode (entered from 2-bit width)
        mode_tx(8'h38, 4);
        hold_n = 1'b0;
        wr_tx(24'd700, 2);
        rd_tx(24'd700, 2, "R10 x4 hold ignored");
        hold_n = 1'b1;

        // R6: return command sent at 4-bit width
        mode_tx(8'hFF, 1);
        rd_tx(24'd700, 1, "R6 x1 after x4");

        // Random mixed traffic
        for (int it = 0; it < 40; it++) begin
            int r, n;
            logic [23:0] a;
            r = int'($urandom % 8);
            n = 1 + int'($urandom % 4);
            a = 24'($urandom);
            if (r == 0)      mode_tx(8'h3B, 2);
            else if (r == 1) mode_tx(8'h38, 4);
            else if (r == 2) mode_tx(8'hFF, 1);
            else if (r < 5)  wr_tx(a, n);
            else             rd_tx(a, n, "R3 R4 random traffic");
        end

        finish_run();
    end
endmodule